// File: doc/BRIEF.md
# Compacted Scan Expansion Network

This block loads test patterns into thirteen core scan cells through a scan path only four stages deep. Scan cells whose test data never conflict are grouped so that they share one stage. Each stage drives every cell of its group, and cells fed through XOR logic receive the value unchanged. A cell whose data is always the complement of its group's value reads the stage value through an inverter. Loading a full 13-cell pattern therefore takes four shift clocks instead of thirteen. Pattern storage falls from 13 to 4 bits per vector, so five vectors take 20 bits instead of 65.

A bypass input selects a plain 13-deep serial chain over the same thirteen cell outputs. A pattern that respects the grouping can be loaded either way, and the two paths must give the same result. The last stage of the selected path drives the serial output, so the loaded data can be shifted back out. The network that is not selected keeps its contents.

Top module: `compact_scan_net`

## Requirements
- R1: While `rst_n` is low, every stage flop and every bypass-chain flop is zero. In compacted mode, `cells` then reads 13'h0420 (only cells 6 and 11 high), and `scan_out` reads 0. `rst_n` asserts asynchronously and is released through a two-flop synchronizer.
- R2: In compacted mode (`bypass`=0) with `scan_en`=1, each rising clock edge loads `scan_in` into stage 1 and moves stage k into stage k+1. After four shifts, the first bit shifted sits in stage 4 and the last bit in stage 1.
- R3: In compacted mode, cell k (bit k-1 of `cells`) follows a fixed stage. Cell 1 follows stage 1. Cells 2, 3, 5, 9, 10 and 12 follow stage 2. Cells 4 and 6 follow stage 3. Cells 7, 8, 11 and 13 follow stage 4.
- R4: Cells 6 and 11 are inverse-compatible and read the complement of their stage's value. All other cells read it true.
- R5: Cells of multi-cell groups are fed through cascaded 3-input XOR gates whose inputs all carry the stage value. Each such cell follows its stage for both values 0 and 1 and never stays at a constant.
- R6: In compacted mode, `scan_out` equals stage 4.
- R7: In bypass mode (`bypass`=1) with `scan_en`=1, each rising edge loads `scan_in` into cell 1 and moves cell k into cell k+1. `cells` shows the chain uninverted, and `scan_out` equals cell 13.
- R8: With `scan_en`=0, `cells` and `scan_out` hold their values whatever `scan_in` does.
- R9: Shifting in one mode leaves the other mode's flops unchanged.
- R10: Any pattern that respects the groups and inversions gives the same 13-bit `cells` value after 4 compacted shifts as after 13 bypass shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Shift enable for the selected path |
| bypass | input | 1 | 1 selects the plain 13-deep chain, 0 the compacted network |
| scan_in | input | 1 | Serial test data in |
| scan_out | output | 1 | Serial data out from the last flop of the selected path |
| cells | output | 13 | Parallel values presented to the thirteen core scan cells |

## Verification
The bench sweeps all sixteen stage combinations through the compacted path. This catches a cell wired to the wrong stage, a wrong or missing inversion on cells 6 and 11, and an XOR tree with an even input count (such a cell would read a constant 0). Each pattern is then reloaded through the 13-deep chain. The bench checks the two paths for equality, which also exposes a reversed shift direction or an off-by-one chain. Further checks cover three faults: a design that shifts without an enable shows up in the hold checks, one that shares flops between the modes in the cross-mode preservation checks, and a reset that misses the inverted cells in a mid-run reset check.

// File: rtl/compact_scan_pkg.sv
package compact_scan_pkg;
  localparam int NUM_CELLS  = 13;
  localparam int NUM_STAGES = 4;
  localparam int STG_W      = $clog2(NUM_STAGES);

  typedef logic [NUM_CELLS-1:0][STG_W-1:0] cell_map_t;

  // stage index (0 = stage nearest scan input) for cells 13 down to 1
  localparam cell_map_t DEF_CELL_MAP = {
    2'd3, 2'd1, 2'd3, 2'd1, 2'd1, 2'd3, 2'd3,
    2'd2, 2'd1, 2'd2, 2'd1, 2'd1, 2'd0
  };
  // cells driven through an inverter (cells 6 and 11)
  localparam logic [NUM_CELLS-1:0] DEF_INV_MASK = 13'h0420;
  // cells fed through the XOR cascade (all members of multi-cell groups)
  localparam logic [NUM_CELLS-1:0] DEF_XOR_MASK = 13'h1FFE;
endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      rst_q  <= meta_q;
    end
  end
endmodule

// File: rtl/scan_shreg.sv
module scan_shreg #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             din,
  output logic [DEPTH-1:0] q
);
  logic [DEPTH-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = {q[DEPTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/odd_xor3.sv
module odd_xor3 (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic y
);
  assign y = a ^ b ^ c;
endmodule

// File: rtl/scan_cell_expand.sv
module scan_cell_expand
  import compact_scan_pkg::*;
#(
  parameter int                   N_CELLS  = NUM_CELLS,
  parameter int                   N_STAGES = NUM_STAGES,
  parameter cell_map_t            CELL_MAP = DEF_CELL_MAP,
  parameter logic [N_CELLS-1:0]   INV_MASK = DEF_INV_MASK,
  parameter logic [N_CELLS-1:0]   XOR_MASK = DEF_XOR_MASK
) (
  input  logic [N_STAGES-1:0] stg,
  output logic [N_CELLS-1:0]  cell_val
);
  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    logic sv;
    logic fed;
    assign sv = stg[CELL_MAP[k]];
    if (XOR_MASK[k]) begin : g_xor
      logic lvl1;
      odd_xor3 u_x1 (.a(sv),   .b(sv),   .c(sv), .y(lvl1));
      odd_xor3 u_x2 (.a(lvl1), .b(lvl1), .c(sv), .y(fed));
    end else begin : g_direct
      assign fed = sv;
    end
    if (INV_MASK[k]) begin : g_inv
      assign cell_val[k] = ~fed;
    end else begin : g_true
      assign cell_val[k] = fed;
    end
  end
endmodule

// File: rtl/compact_scan_net.sv
module compact_scan_net
  import compact_scan_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scan_en,
  input  logic                 bypass,
  input  logic                 scan_in,
  output logic                 scan_out,
  output logic [NUM_CELLS-1:0] cells
);
  logic                  rst_q;
  logic                  shift_cmp;
  logic                  shift_byp;
  logic [NUM_STAGES-1:0] stg_q;
  logic [NUM_CELLS-1:0]  chain_q;
  logic [NUM_CELLS-1:0]  exp_val;

  scan_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q(rst_q));

  assign shift_cmp = scan_en & ~bypass;
  assign shift_byp = scan_en &  bypass;

  scan_shreg #(.DEPTH(NUM_STAGES)) u_stages (
    .clk(clk), .rst_n(rst_q), .en(shift_cmp), .din(scan_in), .q(stg_q)
  );

  scan_shreg #(.DEPTH(NUM_CELLS)) u_chain (
    .clk(clk), .rst_n(rst_q), .en(shift_byp), .din(scan_in), .q(chain_q)
  );

  scan_cell_expand u_expand (.stg(stg_q), .cell_val(exp_val));

  assign cells    = bypass ? chain_q : exp_val;
  assign scan_out = bypass ? chain_q[NUM_CELLS-1] : stg_q[NUM_STAGES-1];
endmodule

// File: rtl/compact_scan_chk.sv
module compact_scan_chk
  import compact_scan_pkg::*;
(
  input logic                  clk,
  input logic                  rst_q,
  input logic                  scan_en,
  input logic                  bypass,
  input logic                  scan_in,
  input logic                  scan_out,
  input logic [NUM_CELLS-1:0]  cells,
  input logic [NUM_STAGES-1:0] stg,
  input logic [NUM_CELLS-1:0]  chain
);
  p_stage_load_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (scan_en && !bypass) |=> (stg[0] == $past(scan_in)) && (stg[3:1] == $past(stg[2:0])));

  p_cell1_map_r3: assert property (@(posedge clk) disable iff (!rst_q)
    !bypass |-> (cells[0] == stg[0]));

  p_inverted_r4: assert property (@(posedge clk) disable iff (!rst_q)
    !bypass |-> (cells[5] != stg[2]) && (cells[10] != stg[3]));

  p_xor_pass_r5: assert property (@(posedge clk) disable iff (!rst_q)
    !bypass |-> (cells[12] == stg[3]) && (cells[1] == stg[1]));

  p_sout_cmp_r6: assert property (@(posedge clk) disable iff (!rst_q)
    !bypass |-> (scan_out == stg[3]));

  p_chain_load_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (scan_en && bypass) |=> (cells[0] == $past(scan_in)) || !bypass);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_q)
    !scan_en |=> (bypass != $past(bypass)) || ($stable(cells) && $stable(scan_out)));

  p_other_kept_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (scan_en && !bypass) |=> $stable(chain));
endmodule

bind compact_scan_net compact_scan_chk u_chk (
  .clk(clk), .rst_q(rst_q), .scan_en(scan_en), .bypass(bypass),
  .scan_in(scan_in), .scan_out(scan_out), .cells(cells),
  .stg(stg_q), .chain(chain_q)
);

// File: tb/tb_compact_scan_net.sv
module tb_compact_scan_net;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        scan_en;
  logic        bypass;
  logic        scan_in;
  logic        scan_out;
  logic [12:0] cells;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  compact_scan_net dut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .bypass(bypass),
    .scan_in(scan_in), .scan_out(scan_out), .cells(cells)
  );

  function automatic int stage_of(int k);
    case (k)
      1:                   return 0;
      2, 3, 5, 9, 10, 12:  return 1;
      4, 6:                return 2;
      default:             return 3;
    endcase
  endfunction

  function automatic logic [12:0] expand(logic [3:0] v);
    logic [12:0] e;
    for (int k = 1; k <= 13; k++)
      e[k-1] = v[stage_of(k)] ^ ((k == 6) || (k == 11));
    return e;
  endfunction

  task automatic chk(bit ok, string req, logic [12:0] act, logic [12:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift1(logic b);
    @(negedge clk);
    scan_in = b;
    scan_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    scan_en = 1'b0;
  endtask

  task automatic load_cmp(logic [3:0] v);
    bypass = 1'b0;
    for (int i = 3; i >= 0; i--) shift1(v[i]);
  endtask

  task automatic load_byp(logic [12:0] p);
    bypass = 1'b1;
    for (int i = 12; i >= 0; i--) shift1(p[i]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
  endtask

  initial begin
    rst_n = 1'b0; scan_en = 1'b0; bypass = 1'b0; scan_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(cells == 13'h0420, "R1 reset cells", cells, 13'h0420);
    chk(scan_out == 1'b0, "R1 reset scan_out", {12'b0, scan_out}, 13'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // compacted sweep over every stage combination
    for (int v = 0; v < 16; v++) begin
      logic [12:0] e;
      logic [12:0] held;
      e = expand(v[3:0]);
      load_cmp(v[3:0]);
      chk(cells == e, "R3/R4/R5 compacted pattern", cells, e);
      chk(scan_out == v[3], "R6 scan_out is stage 4", {12'b0, scan_out}, {12'b0, v[3]});
      held = cells;
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        scan_in = ~scan_in;
      end
      chk(cells == held && scan_out == v[3], "R8 hold without scan_en", cells, held);
      // R10: same pattern via the plain chain
      load_byp(e);
      chk(cells == e, "R10 bypass equals compacted", cells, e);
      chk(scan_out == e[12], "R7 scan_out is cell 13", {12'b0, scan_out}, {12'b0, e[12]});
      // R9: return to compacted, stages untouched by bypass shifting
      bypass = 1'b0;
      #1;
      chk(cells == e, "R9 stages kept during bypass shifts", cells, e);
    end

    // R2: shift order, single one walks through stages
    load_cmp(4'b0000);
    shift1(1'b1);
    chk(cells == expand(4'b0001), "R2 first shift into stage 1", cells, expand(4'b0001));
    shift1(1'b0);
    chk(cells == expand(4'b0010), "R2 moves to stage 2", cells, expand(4'b0010));
    shift1(1'b0); shift1(1'b0);
    chk(cells == expand(4'b1000) && scan_out, "R2 reaches stage 4", cells, expand(4'b1000));

    // R7: walking one through the 13-deep chain, and R9 chain kept
    load_byp(13'h0000);
    shift1(1'b1);
    chk(cells == 13'h0001, "R7 enters cell 1", cells, 13'h0001);
    for (int i = 0; i < 12; i++) shift1(1'b0);
    chk(cells == 13'h1000 && scan_out, "R7 reaches cell 13", cells, 13'h1000);
    load_cmp(4'b0110);
    bypass = 1'b1;
    #1;
    chk(cells == 13'h1000, "R9 chain kept during compacted shifts", cells, 13'h1000);

    // R1: mid-run reset
    bypass = 1'b0;
    load_cmp(4'b1111);
    do_reset();
    chk(cells == 13'h0420, "R1 mid-run reset cells", cells, 13'h0420);
    chk(scan_out == 1'b0, "R1 mid-run reset scan_out", {12'b0, scan_out}, 13'h0);
    bypass = 1'b1;
    #1;
    chk(cells == 13'h0000, "R1 reset clears chain", cells, 13'h0000);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule